// File: doc/BRIEF.md
# Dual-Bank Direct-Lookup Input Gamma Table

This block maps each color component of an incoming pixel through a table with one entry per input code, and does not interpolate. Red, green and blue each index their own table. Two complete copies of the table, bank A and bank B, are held side by side. The pixel path reads the bank chosen by the lookup mode. The host rewrites the other bank at the same time through a separate write port, so the pixel path never stalls.

The host loads a bank through a single sequential data port. It first clears the write index. Each group of three writes then fills the red, green and blue slots of one entry, and the index advances after the blue slot. A 3-bit mask can skip individual channels while still consuming their slots. Writes are taken only while the host holds the memory power-disable control at 1. The host drops that control once the bank is full.

A registered status code tells the host which bank the pixel path is reading. The code also shows whether a load is under way and which bank that load targets. The host uses it to pick the unoccupied bank, fill it, and then switch the lookup mode over to it.

Top module: `igam_lut`

## Requirements
- R1: After reset, `out_valid` is 0, `out_r`, `out_g` and `out_b` are 0, and `lut_status` is 0.
- R2: After a pulse on `host_idx_clr`, successive accepted writes on `host_seq_data` go to the red, green and blue slots of entry 0, in that order. The index then steps to the next entry. A write in the same cycle as the clear is dropped.
- R3: In `host_wr_mask`, bit 0 enables red, bit 1 green and bit 2 blue. A write landing on a channel whose bit is 0 leaves that slot unchanged, but the sequence still moves on to the next slot.
- R4: `host_wr_bank` = 0 writes bank A and 1 writes bank B. Loading one bank never changes the other bank, and never stalls lookups from it, even in the same cycle as a write.
- R5: The lookup mode selects the output. Mode 2 reads bank A and mode 3 reads bank B. Modes 0 and 1 are bypass: the input is placed in the upper bits of the output and the lower DATA_W-IN_W bits are 0.
- R6: A pixel presented with `pix_valid` appears on the outputs on the next clock edge, with `out_valid` = 1. When `pix_valid` is 0, `out_valid` is 0 on the next cycle.
- R7: One cycle after its inputs, `lut_status` shows one of the following codes.
  - 0: idle, in modes 0 and 1.
  - 1: bank A in use, no load.
  - 2: bank B in use, no load.
  - 3: A in use, loading B.
  - 4: A in use, loading A.
  - 5: B in use, loading A.
  - 6: B in use, loading B.
  - A load means `host_mem_pwr_dis` is 1 and is aimed at the bank given by `host_wr_bank`.
- R8: While `host_mem_pwr_dis` is 0, writes on the data port change neither the table nor the write position.
- R9: After the blue slot of entry 255, the write index wraps to entry 0.
- R10: Each of the three components indexes only its own channel's table within the selected bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_bank | input | 1 | Bank to be written: 0 = A, 1 = B |
| host_wr_mask | input | 3 | Per-channel write enable (bit 0 red, bit 1 green, bit 2 blue) |
| host_mem_pwr_dis | input | 1 | Memory power-disable; 1 while loading, writes accepted only then |
| host_idx_clr | input | 1 | Returns the write position to entry 0, red slot |
| host_seq_wr | input | 1 | Write strobe for the sequential data port |
| host_seq_data | input | DATA_W | Table value for the current slot |
| lut_mode | input | 2 | 0/1 bypass, 2 bank A, 3 bank B |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | IN_W | Red component / red table index |
| pix_g | input | IN_W | Green component / green table index |
| pix_b | input | IN_W | Blue component / blue table index |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | DATA_W | Mapped red |
| out_g | output | DATA_W | Mapped green |
| out_b | output | DATA_W | Mapped blue |
| lut_status | output | 3 | Bank occupancy and load code |

## Verification
Each bank is loaded with values that encode bank, channel and index, so a wrong bank, a swapped channel or an off-by-one index each show up as a distinct wrong value.

The lookup vectors cover the following cases:
- All four modes.
- Codes 0 and 255.
- Unequal red, green and blue in one pixel, which catches crossed channels.

A lookup taken from bank A while bank B is being written shows that the two banks are independent. Directed sequences cover the remaining rules:
- Partial masks, where skipped slots must still advance the position.
- Writes made while power-disable is low.
- Index wrap after a full load plus three more writes.
- Every status code.

// File: rtl/igam_pkg.sv
package igam_pkg;

    localparam int NUM_CH = 3;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_RSVD   = 2'd1,
        MODE_BANK_A = 2'd2,
        MODE_BANK_B = 2'd3
    } lut_mode_e;

    localparam logic [2:0] ST_IDLE     = 3'd0;
    localparam logic [2:0] ST_A        = 3'd1;
    localparam logic [2:0] ST_B        = 3'd2;
    localparam logic [2:0] ST_A_LOAD_B = 3'd3;
    localparam logic [2:0] ST_A_LOAD_A = 3'd4;
    localparam logic [2:0] ST_B_LOAD_A = 3'd5;
    localparam logic [2:0] ST_B_LOAD_B = 3'd6;

endpackage

// File: rtl/igam_wr_seq.sv
module igam_wr_seq #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic             pwr_dis,
    input  logic [2:0]       mask,
    output logic [IDX_W-1:0] idx,
    output logic [2:0]       ch_we
);
    localparam logic [1:0] LAST_CH = 2'd2;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [1:0]       ch;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept;

    always_comb begin
        accept = wr && pwr_dis && !clr;
        seq_d  = seq_q;
        if (clr) begin
            seq_d = '0;
        end else if (accept) begin
            if (seq_q.ch == LAST_CH) begin
                seq_d.ch  = 2'd0;
                seq_d.idx = seq_q.idx + 1'b1;
            end else begin
                seq_d.ch = seq_q.ch + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    for (genvar c = 0; c < 3; c++) begin : g_we
        assign ch_we[c] = accept && (seq_q.ch == 2'(c)) && mask[c];
    end

    assign idx = seq_q.idx;

    assert_ch_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ch != 2'd3);

    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && pwr_dis && !clr && seq_q.ch != LAST_CH)
        |=> (seq_q.ch == $past(seq_q.ch) + 2'd1) && $stable(seq_q.idx));

    assert_idx_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && pwr_dis && !clr && seq_q.ch == LAST_CH)
        |=> (seq_q.idx == IDX_W'($past(seq_q.idx) + 1'b1)) && seq_q.ch == 2'd0);

    assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dis && !clr) |=> $stable(seq_q));

    assert_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> seq_q == '0);

endmodule

// File: rtl/igam_bank.sv
module igam_bank #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 12
) (
    input  logic                        clk,
    input  logic [2:0]                  we,
    input  logic [IDX_W-1:0]            waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [2:0][IDX_W-1:0]       raddr,
    output logic [2:0][DATA_W-1:0]      rdata
);
    localparam int ENTRIES = 1 << IDX_W;

    for (genvar c = 0; c < 3; c++) begin : g_ch
        logic [DATA_W-1:0] mem [ENTRIES];

        always_ff @(posedge clk) begin
            if (we[c]) mem[waddr] <= wdata;
        end

        assign rdata[c] = mem[raddr[c]];
    end

endmodule

// File: rtl/igam_status.sv
module igam_status
    import igam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       pwr_dis,
    input  logic       wr_bank,
    output logic [2:0] status
);
    logic [2:0] status_d, status_q;

    always_comb begin
        status_d = ST_IDLE;
        if (mode == MODE_BANK_A) begin
            if (!pwr_dis)     status_d = ST_A;
            else if (wr_bank) status_d = ST_A_LOAD_B;
            else              status_d = ST_A_LOAD_A;
        end else if (mode == MODE_BANK_B) begin
            if (!pwr_dis)     status_d = ST_B;
            else if (wr_bank) status_d = ST_B_LOAD_B;
            else              status_d = ST_B_LOAD_A;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= ST_IDLE;
        else        status_q <= status_d;
    end

    assign status = status_q;

    assert_status_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_q != 3'd7);

    assert_status_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |=> status_q == ST_IDLE);

    assert_status_bank_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BANK_A) |=> (status_q == ST_A || status_q == ST_A_LOAD_B || status_q == ST_A_LOAD_A));

endmodule

// File: rtl/igam_lut.sv
module igam_lut
    import igam_pkg::*;
#(
    parameter int IN_W   = 8,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_bank,
    input  logic [2:0]        host_wr_mask,
    input  logic              host_mem_pwr_dis,
    input  logic              host_idx_clr,
    input  logic              host_seq_wr,
    input  logic [DATA_W-1:0] host_seq_data,
    input  logic [1:0]        lut_mode,
    input  logic              pix_valid,
    input  logic [IN_W-1:0]   pix_r,
    input  logic [IN_W-1:0]   pix_g,
    input  logic [IN_W-1:0]   pix_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_r,
    output logic [DATA_W-1:0] out_g,
    output logic [DATA_W-1:0] out_b,
    output logic [2:0]        lut_status
);
    localparam int PAD = DATA_W - IN_W;

    typedef struct packed {
        logic                   valid;
        logic [2:0][DATA_W-1:0] px;
    } pipe_t;

    logic [IN_W-1:0]          wr_idx;
    logic [2:0]               ch_we;
    logic [2:0]               we_a, we_b;
    logic [2:0][IN_W-1:0]     pix_in;
    logic [2:0][DATA_W-1:0]   rd_a, rd_b;
    pipe_t                    pipe_d, pipe_q;

    assign pix_in = {pix_b, pix_g, pix_r};
    assign we_a   = ch_we & {3{~host_wr_bank}};
    assign we_b   = ch_we & {3{host_wr_bank}};

    igam_wr_seq #(.IDX_W(IN_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (host_idx_clr),
        .wr      (host_seq_wr),
        .pwr_dis (host_mem_pwr_dis),
        .mask    (host_wr_mask),
        .idx     (wr_idx),
        .ch_we   (ch_we)
    );

    igam_bank #(.IDX_W(IN_W), .DATA_W(DATA_W)) u_bank_a (
        .clk   (clk),
        .we    (we_a),
        .waddr (wr_idx),
        .wdata (host_seq_data),
        .raddr (pix_in),
        .rdata (rd_a)
    );

    igam_bank #(.IDX_W(IN_W), .DATA_W(DATA_W)) u_bank_b (
        .clk   (clk),
        .we    (we_b),
        .waddr (wr_idx),
        .wdata (host_seq_data),
        .raddr (pix_in),
        .rdata (rd_b)
    );

    igam_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (lut_mode),
        .pwr_dis (host_mem_pwr_dis),
        .wr_bank (host_wr_bank),
        .status  (lut_status)
    );

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.valid = pix_valid;
        if (pix_valid) begin
            for (int c = 0; c < 3; c++) begin
                case (lut_mode)
                    MODE_BANK_A: pipe_d.px[c] = rd_a[c];
                    MODE_BANK_B: pipe_d.px[c] = rd_b[c];
                    default:     pipe_d.px[c] = DATA_W'(pix_in[c]) << PAD;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.valid;
    assign out_r     = pipe_q.px[0];
    assign out_g     = pipe_q.px[1];
    assign out_b     = pipe_q.px[2];

    assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !lut_mode[1])
        |=> out_r == (DATA_W'($past(pix_r)) << PAD) && out_b == (DATA_W'($past(pix_b)) << PAD));

    assert_bank_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|we_a, |we_b}));

endmodule

// File: tb/igam_lut_tb.sv
module igam_lut_tb;
    localparam int IN_W   = 8;
    localparam int DATA_W = 12;
    localparam int PAD    = DATA_W - IN_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr_bank = 1'b0;
    logic [2:0]        host_wr_mask = 3'b111;
    logic              host_mem_pwr_dis = 1'b0;
    logic              host_idx_clr = 1'b0;
    logic              host_seq_wr = 1'b0;
    logic [DATA_W-1:0] host_seq_data = '0;
    logic [1:0]        lut_mode = 2'd0;
    logic              pix_valid = 1'b0;
    logic [IN_W-1:0]   pix_r = '0, pix_g = '0, pix_b = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_r, out_g, out_b;
    logic [2:0]        lut_status;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    igam_lut #(.IN_W(IN_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_bank(host_wr_bank), .host_wr_mask(host_wr_mask),
        .host_mem_pwr_dis(host_mem_pwr_dis), .host_idx_clr(host_idx_clr),
        .host_seq_wr(host_seq_wr), .host_seq_data(host_seq_data),
        .lut_mode(lut_mode), .pix_valid(pix_valid),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .lut_status(lut_status)
    );

    // mode[1:0], r, g, b
    localparam logic [25:0] VEC [10] = '{
        {2'd2, 8'd0,   8'd1,   8'd2},
        {2'd2, 8'd255, 8'd128, 8'd3},
        {2'd3, 8'd0,   8'd0,   8'd0},
        {2'd3, 8'd17,  8'd200, 8'd255},
        {2'd0, 8'd255, 8'd1,   8'd90},
        {2'd1, 8'd12,  8'd34,  8'd56},
        {2'd2, 8'd77,  8'd77,  8'd77},
        {2'd3, 8'd254, 8'd253, 8'd252},
        {2'd0, 8'd0,   8'd0,   8'd0},
        {2'd2, 8'd9,   8'd250, 8'd100}
    };

    function automatic logic [DATA_W-1:0] val(int bank, int ch, int i);
        return DATA_W'((bank * 1024 + ch * 256 + i) ^ 12'h0A5);
    endfunction

    function automatic logic [DATA_W-1:0] expect_px(logic [1:0] mode, int ch, logic [IN_W-1:0] x);
        if (mode == 2'd2) return val(0, ch, int'(x));
        if (mode == 2'd3) return val(1, ch, int'(x));
        return DATA_W'(x) << PAD;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_word(logic [DATA_W-1:0] d);
        host_seq_wr = 1'b1;
        host_seq_data = d;
        @(negedge clk);
        host_seq_wr = 1'b0;
    endtask

    task automatic idx_clear();
        host_idx_clr = 1'b1;
        @(negedge clk);
        host_idx_clr = 1'b0;
    endtask

    task automatic lookup(string req, logic [1:0] mode, logic [IN_W-1:0] r,
                          logic [IN_W-1:0] g, logic [IN_W-1:0] b,
                          logic [DATA_W-1:0] er, logic [DATA_W-1:0] eg, logic [DATA_W-1:0] eb);
        lut_mode = mode; pix_valid = 1'b1;
        pix_r = r; pix_g = g; pix_b = b;
        @(negedge clk);
        pix_valid = 1'b0;
        chk({req, " R6 valid"}, 32'(out_valid), 32'd1);
        chk({req, " red"},   32'(out_r), 32'(er));
        chk({req, " green"}, 32'(out_g), 32'(eg));
        chk({req, " blue"},  32'(out_b), 32'(eb));
    endtask

    // Full load of one bank; optional probe of bank A mid-load (R4)
    task automatic load_bank(int bank, bit probe);
        host_wr_bank = 1'(bank);
        host_mem_pwr_dis = 1'b1;
        host_wr_mask = 3'b111;
        idx_clear();
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) begin
                host_seq_wr = 1'b1;
                host_seq_data = val(bank, c, i);
                if (probe && i == 100 && c == 1) begin
                    pix_valid = 1'b1; pix_r = 8'd7; pix_g = 8'd8; pix_b = 8'd9;
                end
                @(negedge clk);
                host_seq_wr = 1'b0;
                if (probe && i == 100 && c == 1) begin
                    pix_valid = 1'b0;
                    chk("R4 lookup A during B load red",   32'(out_r), 32'(val(0, 0, 7)));
                    chk("R4 lookup A during B load green", 32'(out_g), 32'(val(0, 1, 8)));
                    chk("R4 lookup A during B load blue",  32'(out_b), 32'(val(0, 2, 9)));
                end
            end
        end
    endtask

    task automatic status_is(string req, logic [1:0] mode, logic pwr, logic bank, logic [2:0] exp);
        lut_mode = mode; host_mem_pwr_dis = pwr; host_wr_bank = bank;
        @(negedge clk);
        chk(req, 32'(lut_status), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 out_r", 32'(out_r), 32'd0);
        chk("R1 out_b", 32'(out_b), 32'd0);
        chk("R1 status", 32'(lut_status), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 idle while loading bank A in bypass
        status_is("R7 idle code", 2'd0, 1'b1, 1'b0, 3'd0);
        load_bank(0, 1'b0);
        status_is("R7 A in use", 2'd2, 1'b0, 1'b0, 3'd1);
        status_is("R7 A use B load", 2'd2, 1'b1, 1'b1, 3'd3);
        load_bank(1, 1'b1);
        status_is("R7 A use A load", 2'd2, 1'b1, 1'b0, 3'd4);
        status_is("R7 B in use", 2'd3, 1'b0, 1'b0, 3'd2);
        status_is("R7 B use A load", 2'd3, 1'b1, 1'b0, 3'd5);
        status_is("R7 B use B load", 2'd3, 1'b1, 1'b1, 3'd6);
        status_is("R7 mode1 idle", 2'd1, 1'b0, 1'b0, 3'd0);

        // R5/R10 vector table walk
        foreach (VEC[k]) begin
            logic [1:0] m;
            logic [IN_W-1:0] r, g, b;
            {m, r, g, b} = VEC[k];
            lookup("R5 R10 vector", m, r, g, b,
                   expect_px(m, 0, r), expect_px(m, 1, g), expect_px(m, 2, b));
        end
        @(negedge clk);
        chk("R6 valid drops", 32'(out_valid), 32'd0);

        // R3: partial mask skips green slot but still advances
        host_wr_bank = 1'b0; host_mem_pwr_dis = 1'b1;
        idx_clear();
        host_wr_mask = 3'b101;
        wr_word(12'hABC); wr_word(12'h111); wr_word(12'hDEF);
        host_wr_mask = 3'b111;
        wr_word(12'h321); wr_word(12'h654); wr_word(12'h987);
        host_mem_pwr_dis = 1'b0;
        lookup("R3 masked entry0", 2'd2, 8'd0, 8'd0, 8'd0, 12'hABC, val(0, 1, 0), 12'hDEF);
        lookup("R3 R2 entry1 after skip", 2'd2, 8'd1, 8'd1, 8'd1, 12'h321, 12'h654, 12'h987);

        // R8: writes ignored while power-disable is low
        host_mem_pwr_dis = 1'b1;
        idx_clear();
        host_mem_pwr_dis = 1'b0;
        wr_word(12'hEEE); wr_word(12'hEEE); wr_word(12'hEEE);
        lookup("R8 no write when pwr low", 2'd2, 8'd0, 8'd0, 8'd0, 12'hABC, val(0, 1, 0), 12'hDEF);
        host_mem_pwr_dis = 1'b1;
        wr_word(12'h0A1); wr_word(12'h0A2); wr_word(12'h0A3);
        lookup("R8 R2 position held", 2'd2, 8'd0, 8'd0, 8'd0, 12'h0A1, 12'h0A2, 12'h0A3);

        // R2: clear mid-entry restarts at red of entry 0; R4 bank B untouched
        wr_word(12'h0B1);
        idx_clear();
        wr_word(12'h0C1); wr_word(12'h0C2); wr_word(12'h0C3);
        lookup("R2 clear mid-entry", 2'd2, 8'd0, 8'd0, 8'd0, 12'h0C1, 12'h0C2, 12'h0C3);
        lookup("R4 bank B unchanged", 2'd3, 8'd0, 8'd1, 8'd0, val(1, 0, 0), val(1, 1, 1), val(1, 2, 0));

        // R9: full load of bank B then three more writes wrap to entry 0
        load_bank(1, 1'b0);
        wr_word(12'h5A1); wr_word(12'h5A2); wr_word(12'h5A3);
        host_mem_pwr_dis = 1'b0;
        lookup("R9 wrap entry0", 2'd3, 8'd0, 8'd0, 8'd0, 12'h5A1, 12'h5A2, 12'h5A3);
        lookup("R9 entry1 intact", 2'd3, 8'd1, 8'd255, 8'd1, val(1, 0, 1), val(1, 1, 255), val(1, 2, 1));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule